// File: doc/BRIEF.md
# Two-Level Rotating Priority Interrupt Selector

This block reduces a 32-bit vector of already-unmasked interrupt requests to a single winner. The winner is reported as a valid flag and a 5-bit source number. The selection runs in two combinational stages. Six group arbiters each pick one request from their own group of sources. A final arbiter then picks one of the six group winners. Every arbiter has a fixed-versus-rotating mode bit and a two-bit order select. All seven arbiters' controls sit in one 21-bit control word that software writes and reads as a whole.

Every arbiter has six input slots. Slot 0 always has the highest priority and slot 5 always has the lowest. The order of the four middle slots comes from that arbiter's select field. When the consumer takes the current winner by raising `ack`, each arbiter on the winning path that has rotation enabled advances its select field. This places the slot it just granted last among the middle four. The new field value is written back into the control word, so software sees it.

Source wiring is as follows:
- Group 0 carries sources 0 to 3 on its middle slots 1 to 4.
- Groups 1 to 4 carry six sources each, on slots 0 to 5: sources 4–9, 10–15, 16–21 and 22–27.
- Group 5 carries sources 28 to 31 on slots 0 to 3.
- Unused slots are tied low.

Top module: `prio_tree_arb`

## Requirements
- R1: After a synchronous active-high reset, the control word reads 0x7F: every mode bit is 1 and every select field is 00.
- R2: `win_valid` is 1 exactly when at least one bit of `req` is 1. When it is 1, `req[win_idx]` is 1.
- R3: Source wiring follows the slot map given above. In any arbiter, an active slot 0 beats every other slot, and slot 5 wins only when no other slot is active, whatever the select field holds.
- R4: A select field orders the middle slots as follows, highest priority first: 00 gives 1,2,3,4; 01 gives 2,3,4,1; 10 gives 3,4,1,2; 11 gives 4,1,2,3. In group 0 this is the order of sources 0..3 shifted by the field.
- R5: The final arbiter treats group k as its slot k, and its select field applies to groups 1 to 4. The winning source is the winning group's choice.
- R6: Control word layout: bit a is the mode bit of arbiter a (0..6, where 6 is the final arbiter), and select field a occupies bits 7+2a and 8+2a. A write with `cfg_we` replaces the whole word at the next clock edge, and `cfg_rdata` always shows the word.
- R7: On a clock edge with `ack` high and `win_valid` high, each arbiter on the winning path whose mode bit is 1 and which granted a middle slot m (1..4) sets its select field to m mod 4. A grant of slot 0 or slot 5 leaves the field unchanged.
- R8: `ack` never changes a select field of an arbiter that is off the winning path or has mode bit 0, and never changes any mode bit.
- R9: `ack` while `win_valid` is 0 leaves the control word unchanged.
- R10: When `cfg_we` and `ack` are high in the same cycle, the written word is stored and the rotation update is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 32 | Unmasked interrupt requests, one bit per source |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 21 | New control word |
| cfg_rdata | output | 21 | Current control word |
| ack | input | 1 | Current winner taken; advances rotating arbiters |
| win_valid | output | 1 | Some request is active |
| win_idx | output | 5 | Source number of the winner |

## Verification
The assertions assume that `req`, `ack`, `cfg_we` and `cfg_wdata` are known and stable around each rising edge. They also assume that reset is held high from time zero, so the control word has a defined value before the first rotation. The bench honours this by changing all inputs only at falling edges, by holding reset through the first cycles, and by sampling outputs at the falling edge after the update. Table vectors install each control word by a single write before sampling, so every expected winner depends only on that word and the request pattern.

// File: rtl/prio_tree_pkg.sv
package prio_tree_pkg;

    // Structure of the arbitration tree
    localparam int SLOTS   = 6;                 // inputs per arbiter
    localparam int MID_N   = SLOTS - 2;         // rotating middle slots
    localparam int GROUPS  = 6;                 // first-level arbiters
    localparam int ARBS    = GROUPS + 1;        // plus the final arbiter
    localparam int SRC_N   = 32;                // interrupt sources
    localparam int IDX_W   = $clog2(SRC_N);
    localparam int POS_W   = $clog2(SLOTS);
    localparam int SEL_W   = $clog2(MID_N);
    localparam int CFG_W   = ARBS + ARBS * SEL_W;
    localparam int G0_SRCS = 4;                 // sources on group 0 (middle slots)

    typedef logic [CFG_W-1:0] cfg_t;
    localparam cfg_t CFG_RESET = cfg_t'((1 << ARBS) - 1);

    typedef struct packed {
        logic             rot;
        logic [SEL_W-1:0] sel;
    } arb_ctl_t;

    typedef struct packed {
        logic             vld;
        logic [POS_W-1:0] pos;
    } grant_t;

    // Control fields of arbiter a inside the packed word
    function automatic arb_ctl_t ctl_of(cfg_t c, int a);
        arb_ctl_t r;
        r.rot = c[a];
        r.sel = c[ARBS + SEL_W * a +: SEL_W];
        return r;
    endfunction

    // Slot that holds priority rank r (0 = highest) for a given select value
    function automatic logic [POS_W-1:0] slot_at(logic [SEL_W-1:0] sel, int r);
        int v;
        if (r == 0)
            v = 0;
        else if (r == SLOTS - 1)
            v = SLOTS - 1;
        else
            v = 1 + ((r - 1 + int'(sel)) % MID_N);
        return POS_W'(v);
    endfunction

    function automatic logic is_mid(logic [POS_W-1:0] p);
        return (p >= POS_W'(1)) && (p <= POS_W'(MID_N));
    endfunction

    // Select value that puts middle slot p last: start the order after p
    function automatic logic [SEL_W-1:0] sel_after(logic [POS_W-1:0] p);
        return SEL_W'(int'(p) % MID_N);
    endfunction

    // Does slot p of group g carry a source
    function automatic logic slot_used(int g, int p);
        int s;
        if (g == 0)
            return (p >= 1) && (p <= G0_SRCS);
        s = G0_SRCS + SLOTS * (g - 1) + p;
        return s < SRC_N;
    endfunction

    // Source number wired to slot p of group g
    function automatic int src_of(int g, int p);
        if (g == 0)
            return p - 1;
        return G0_SRCS + SLOTS * (g - 1) + p;
    endfunction

endpackage

// File: rtl/prio_slot_arb.sv
module prio_slot_arb
    import prio_tree_pkg::*;
(
    input  logic [SLOTS-1:0] req,
    input  logic [SEL_W-1:0] sel,
    output grant_t           gnt
);

    // Walk ranks from lowest to highest so the highest-ranked live slot is kept
    always_comb begin
        gnt = '0;
        for (int r = SLOTS - 1; r >= 0; r--) begin
            if (req[slot_at(sel, r)]) begin
                gnt.vld = 1'b1;
                gnt.pos = slot_at(sel, r);
            end
        end
    end

endmodule

// File: rtl/prio_cfg_reg.sv
module prio_cfg_reg
    import prio_tree_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  cfg_t             wr_data,
    input  logic             adv_en,
    input  logic [POS_W-1:0] grp,       // winning group (also final slot)
    input  logic [POS_W-1:0] grp_pos,   // slot granted inside that group
    output cfg_t             cfg_q
);

    cfg_t cfg_n;

    always_comb begin
        cfg_n = cfg_q;
        if (wr_en) begin
            cfg_n = wr_data;
        end else if (adv_en) begin
            for (int a = 0; a < GROUPS; a++) begin
                if (grp == POS_W'(a) && ctl_of(cfg_q, a).rot && is_mid(grp_pos))
                    cfg_n[ARBS + SEL_W * a +: SEL_W] = sel_after(grp_pos);
            end
            if (ctl_of(cfg_q, GROUPS).rot && is_mid(grp))
                cfg_n[ARBS + SEL_W * GROUPS +: SEL_W] = sel_after(grp);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_RESET;
        else
            cfg_q <= cfg_n;
    end

    // R1: word leaving reset holds the reset pattern
    a_r1_reset_value: assert property (@(posedge clk)
        $fell(rst) |-> cfg_q == CFG_RESET);

    // R6 / R10: a write always lands, even alongside an advance
    a_r6_write_lands: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en)) |-> cfg_q == $past(wr_data));

    // R9: nothing moves without a write or an advance
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en) && !$past(adv_en)) |-> $stable(cfg_q));

    // R8: rotation never touches mode bits
    a_r8_mode_kept: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en)) |-> cfg_q[ARBS-1:0] == $past(cfg_q[ARBS-1:0]));

endmodule

// File: rtl/prio_tree_arb.sv
module prio_tree_arb
    import prio_tree_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] req,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             ack,
    output logic             win_valid,
    output logic [IDX_W-1:0] win_idx
);

    cfg_t             cfg_q;
    logic [SLOTS-1:0] grp_req [GROUPS];
    grant_t           grp_gnt [GROUPS];
    logic [SLOTS-1:0] top_req;
    grant_t           top_gnt;
    logic [POS_W-1:0] win_pos;

    // First level: wire sources onto slots and arbitrate each group
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        for (genvar p = 0; p < SLOTS; p++) begin : g_slot
            if (slot_used(g, p)) begin : g_wired
                assign grp_req[g][p] = req[src_of(g, p)];
            end else begin : g_tied
                assign grp_req[g][p] = 1'b0;
            end
        end

        prio_slot_arb u_arb (
            .req (grp_req[g]),
            .sel (ctl_of(cfg_q, g).sel),
            .gnt (grp_gnt[g])
        );

        assign top_req[g] = grp_gnt[g].vld;
    end

    // Second level
    prio_slot_arb u_final (
        .req (top_req),
        .sel (ctl_of(cfg_q, GROUPS).sel),
        .gnt (top_gnt)
    );

    // Winning slot inside the winning group and its source number
    always_comb begin
        win_pos = '0;
        win_idx = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (top_gnt.pos == POS_W'(g)) begin
                win_pos = grp_gnt[g].pos;
                for (int p = 0; p < SLOTS; p++) begin
                    if (slot_used(g, p) && grp_gnt[g].pos == POS_W'(p))
                        win_idx = IDX_W'(src_of(g, p));
                end
            end
        end
    end

    assign win_valid = top_gnt.vld;

    prio_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .adv_en  (ack & top_gnt.vld),
        .grp     (top_gnt.pos),
        .grp_pos (win_pos),
        .cfg_q   (cfg_q)
    );

    assign cfg_rdata = cfg_q;

    // R2: valid flag tracks the request vector
    a_r2_valid_any: assert property (@(posedge clk) disable iff (rst)
        win_valid == (req != '0));

    // R2: the reported source is really requesting
    a_r2_winner_live: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> req[win_idx]);

endmodule

// File: tb/prio_tree_arb_bench.sv
module prio_tree_arb_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 14;

    typedef struct packed {
        logic [31:0] req;
        logic [20:0] cfg;
        logic        vld;
        logic [4:0]  idx;
    } vec_t;

    // Rotation is left off in every table word so no ack is involved
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0001, 21'h000000, 1'b1, 5'd0},   // R3 group0 plain
        '{32'h0000_000F, 21'h000080, 1'b1, 5'd1},   // R4 sel0=01
        '{32'h0000_0009, 21'h000180, 1'b1, 5'd3},   // R4 sel0=11
        '{32'h0000_0005, 21'h000100, 1'b1, 5'd2},   // R4 sel0=10
        '{32'h0000_0250, 21'h000000, 1'b1, 5'd4},   // R3 slot0 first
        '{32'h0000_0220, 21'h000600, 1'b1, 5'd5},   // R3 slot5 last
        '{32'h0000_0300, 21'h000600, 1'b1, 5'd8},   // R4 sel1=11
        '{32'h8000_0001, 21'h000000, 1'b1, 5'd0},   // R5 group0 first
        '{32'h0001_0400, 21'h080000, 1'b1, 5'd10},  // R5 final sel=01
        '{32'h0001_0400, 21'h100000, 1'b1, 5'd16},  // R5 final sel=10
        '{32'h9000_0000, 21'h000000, 1'b1, 5'd28},  // R3 group5
        '{32'h8000_0000, 21'h000000, 1'b1, 5'd31},  // R3 last source
        '{32'h0040_0010, 21'h180000, 1'b1, 5'd22},  // R5 final sel=11
        '{32'h0000_0000, 21'h000000, 1'b0, 5'd0}    // R2 idle
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] req = '0;
    logic        cfg_we = 1'b0;
    logic [20:0] cfg_wdata = '0;
    logic [20:0] cfg_rdata;
    logic        ack = 1'b0;
    logic        win_valid;
    logic [4:0]  win_idx;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prio_tree_arb u_prio_tree_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ack       (ack),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [20:0] w);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset word", 32'(cfg_rdata), 32'h7F);
        check("R2 no request", 32'(win_valid), 32'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            req = VECS[i].req;
            write_cfg(VECS[i].cfg);
            check($sformatf("R6 readback vec%0d", i), 32'(cfg_rdata), 32'(VECS[i].cfg));
            check($sformatf("R2 valid vec%0d", i), 32'(win_valid), 32'(VECS[i].vld));
            if (VECS[i].vld)
                check($sformatf("R3/R4/R5 index vec%0d", i), 32'(win_idx), 32'(VECS[i].idx));
        end

        // R7: rotation walks group 0
        write_cfg(21'h7F);
        req = 32'h0000_000F;
        #1 check("R7 before ack", 32'(win_idx), 32'd0);
        pulse_ack();
        check("R7 sel0 advanced", 32'(cfg_rdata), 32'hFF);
        check("R7 next winner", 32'(win_idx), 32'd1);
        pulse_ack();
        check("R7 sel0 again", 32'(cfg_rdata), 32'h17F);
        check("R7 third winner", 32'(win_idx), 32'd2);

        // R8: losing group keeps its field; final arbiter rotates
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        req = 32'h0000_0420;
        @(negedge clk);
        check("R1 reset again", 32'(cfg_rdata), 32'h7F);
        check("R5 group1 first", 32'(win_idx), 32'd5);
        pulse_ack();
        check("R8 only winning path moved", 32'(cfg_rdata), 32'h8027F);
        check("R5 final rotated", 32'(win_idx), 32'd10);

        // R7: slot 0 grant leaves its group field alone
        write_cfg(21'h7F);
        req = 32'h0000_0010;
        pulse_ack();
        check("R7 slot0 no change", 32'(cfg_rdata), 32'h8007F);

        // R8: mode bits cleared means no rotation
        write_cfg(21'h0);
        req = 32'h0000_000F;
        pulse_ack();
        check("R8 fixed mode", 32'(cfg_rdata), 32'h0);
        check("R8 fixed winner", 32'(win_idx), 32'd0);

        // R10: write beats ack
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = 21'h155555;
        ack = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        ack = 1'b0;
        check("R10 write wins", 32'(cfg_rdata), 32'h155555);

        // R9: ack with nothing pending
        write_cfg(21'h7F);
        req = 32'h0;
        pulse_ack();
        check("R9 idle ack", 32'(cfg_rdata), 32'h7F);
        check("R9 still invalid", 32'(win_valid), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule